// File: doc/BRIEF.md
# Compacted Exercise-Vector Injection Unit

This unit sits in front of a group of inputs feeding timing-critical logic. In functional mode every output is a plain copy of its functional input. When exercise mode is requested, a set of stored vectors is replayed, one per clock cycle, so that the critical nets downstream keep toggling while the surrounding logic is idle.

Each input is given one of four treatments when the block is elaborated:

- It carries no override at all.
- It is forced to logic 0.
- It is forced to logic 1.
- It takes one column of a small constant table.

Only inputs whose stored value changes from one vector to the next spend a table column. As a result, the table is as wide as the number of varying inputs, not as wide as the whole input bus. Inputs with a fixed value cost a multiplexer but no storage. Inputs that are don't-care in every vector cost nothing.

A sequencer walks through the table rows while exercise mode stays on, and wraps back to the first row after the last one. The current row number is an output. A flag marks the cycle in which the final row is applied.

Top module: `exvec_inject`

## Requirements
- R1: While `exercise_en` is low, `ex_out` equals `func_in` in the same cycle, on every bit.
- R2: An input whose class code is 0 (untouched) has `ex_out` equal to its `func_in` bit in both modes.
- R3: In exercise mode, an input with class code 1 drives 0 and an input with class code 2 drives 1, whatever its functional value.
- R4: In exercise mode, an input with class code 3 and column c drives bit `ROM_BITS[vec_idx*N_COL + c]`. Row r occupies bits `[r*N_COL +: N_COL]`.
- R5: While reset is asserted, and on the clock edge after a cycle with `exercise_en` low, `vec_idx` is 0.
- R6: After each clock edge at which `exercise_en` was high, `vec_idx` has advanced by one, wrapping from `N_VEC-1` to 0.
- R7: `pass_done` is high exactly in the cycles where `exercise_en` is high and `vec_idx` equals `N_VEC-1`.
- R8: The first cycle of an exercise period, entered from functional mode, applies row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exercise_en | input | 1 | High selects exercise mode |
| func_in | input | N_IN | Functional input values |
| ex_out | output | N_IN | Values delivered to the critical logic |
| vec_idx | output | IW | Row currently being applied |
| pass_done | output | 1 | High while the last row is applied in exercise mode |

## Verification
The bench builds the block with ten inputs and three vectors, using the following mix:

- Four table columns.
- Three inputs forced to 1.
- One input forced to 0.
- Two untouched inputs.

This mix exercises every class and every column at once. Each column's bit changes across the three rows, so a wrong column or row selection shows up as a bit mismatch. The row count of three is not a power of two, which reaches the wrap from row 2 to row 0 before the index counter overflows naturally.

Exercise periods are cut off mid-pass and restarted. This brings the return to row 0 on re-entry within reach, alongside full passes that end with the completion flag.

// File: rtl/exvec_pkg.sv
package exvec_pkg;

  typedef enum logic [1:0] {
    EX_KEEP = 2'd0,
    EX_ZERO = 2'd1,
    EX_ONE  = 2'd2,
    EX_ROM  = 2'd3
  } ex_class_e;

  // Next row number with wrap at row count n.
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // Flat bit position of (row, column) in the packed table.
  function automatic int unsigned tbl_pos(int unsigned row, int unsigned col,
                                          int unsigned ncol);
    return row * ncol + col;
  endfunction

endpackage

// File: rtl/exvec_seq.sv
module exvec_seq #(
  parameter int N_VEC = 3,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [IW-1:0] LAST = IW'(N_VEC - 1);

  logic [IW-1:0] idx_q;
  logic          at_last;

  assign at_last = (idx_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx_q <= '0;
    else if (!en_i) idx_q <= '0;
    else            idx_q <= IW'(exvec_pkg::wrap_next(int'(idx_q), N_VEC));
  end

  assign idx_o  = idx_q;
  assign last_o = en_i && at_last;

  // R5: leaving or staying out of exercise mode clears the row number
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> idx_q == '0);

  // R6: step by one inside a pass
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !at_last) |=> idx_q == $past(idx_q) + 1'b1);

  // R6: wrap after the final row
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> idx_q == '0);

  // R6: row number never leaves the table
  a_r6_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < N_VEC);
endmodule

// File: rtl/exvec_rom.sv
module exvec_rom #(
  parameter int                     N_VEC    = 3,
  parameter int                     N_COL    = 4,
  parameter int                     IW       = 2,
  parameter logic [N_VEC*N_COL-1:0] ROM_BITS = '0
) (
  input  logic [IW-1:0]    idx_i,
  output logic [N_COL-1:0] row_o
);
  always_comb begin
    row_o = '0;
    for (int r = 0; r < N_VEC; r++) begin
      if (int'(idx_i) == r) row_o = ROM_BITS[r*N_COL +: N_COL];
    end
  end
endmodule

// File: rtl/exvec_lane.sv
module exvec_lane (
  input  logic func_i,
  input  logic force_i,
  input  logic en_i,
  output logic out_o
);
  assign out_o = en_i ? force_i : func_i;
endmodule

// File: rtl/exvec_inject.sv
module exvec_inject #(
  parameter int N_IN  = 10,
  parameter int N_VEC = 3,
  parameter int N_COL = 4,
  parameter int IW    = (N_VEC > 1) ? $clog2(N_VEC) : 1,
  parameter int CW    = (N_COL > 1) ? $clog2(N_COL) : 1,
  // two bits per input: 0 keep, 1 force 0, 2 force 1, 3 table column
  parameter logic [2*N_IN-1:0]      CLASS_MAP = 20'h36F8B,
  // CW bits per input: table column used by class-3 inputs
  parameter logic [CW*N_IN-1:0]     COL_MAP   = 20'h30900,
  // row r at bits [r*N_COL +: N_COL]
  parameter logic [N_VEC*N_COL-1:0] ROM_BITS  = 12'h6A5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exercise_en,
  input  logic [N_IN-1:0] func_in,
  output logic [N_IN-1:0] ex_out,
  output logic [IW-1:0]   vec_idx,
  output logic            pass_done
);
  import exvec_pkg::*;

  logic [IW-1:0]    idx_w;
  logic [N_COL-1:0] row_w;

  exvec_seq #(.N_VEC(N_VEC), .IW(IW)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (exercise_en),
    .idx_o (idx_w),
    .last_o(pass_done)
  );

  exvec_rom #(.N_VEC(N_VEC), .N_COL(N_COL), .IW(IW), .ROM_BITS(ROM_BITS)) u_rom (
    .idx_i(idx_w),
    .row_o(row_w)
  );

  assign vec_idx = idx_w;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    localparam ex_class_e CLS = ex_class_e'(CLASS_MAP[2*i +: 2]);
    localparam int        COL = int'(COL_MAP[CW*i +: CW]);

    if (CLS == EX_KEEP) begin : g_keep
      assign ex_out[i] = func_in[i];
    end else begin : g_mux
      logic frc;
      if (CLS == EX_ZERO) begin : g_z
        assign frc = 1'b0;
      end else if (CLS == EX_ONE) begin : g_o
        assign frc = 1'b1;
      end else begin : g_r
        assign frc = row_w[COL];

        // R4: table-driven lane carries the addressed table bit
        a_r4_table: assert property (@(posedge clk) disable iff (!rst_n)
          exercise_en |-> ex_out[i] == ROM_BITS[tbl_pos(int'(vec_idx), COL, N_COL)]);
      end

      exvec_lane u_lane (
        .func_i (func_in[i]),
        .force_i(frc),
        .en_i   (exercise_en),
        .out_o  (ex_out[i])
      );

      if (CLS != EX_ROM) begin : g_ca
        // R3: constant lanes hold their code's value in exercise mode
        a_r3_const: assert property (@(posedge clk) disable iff (!rst_n)
          exercise_en |-> ex_out[i] == (CLS == EX_ONE));
      end
    end
  end

  // R1: functional mode is transparent
  a_r1_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !exercise_en |-> ex_out == func_in);

  // R8: entry from functional mode starts on row 0
  a_r8_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exercise_en) |-> vec_idx == '0);

  if (N_VEC > 1) begin : g_pulse
    // R7: completion flag lasts a single cycle
    a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
      pass_done |=> !pass_done);
  end
endmodule

// File: tb/sim_exvec_inject.sv
module sim_exvec_inject;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [9:0] fin = '0;
  logic [9:0] xo;
  logic [1:0] vi;
  logic       pd;

  int errors = 0;
  int checks = 0;
  int midx   = 0;
  bit prev_en = 1'b0;

  // class per input: 0 keep, 1 zero, 2 one, 3 table
  int kind [10] = '{3, 2, 0, 2, 3, 3, 2, 1, 3, 0};
  int cidx [10] = '{0, 0, 0, 0, 1, 2, 0, 0, 3, 0};
  logic [3:0] rows [3] = '{4'b0101, 4'b1010, 4'b0110};

  always #4 clk = ~clk;

  exvec_inject u0 (
    .clk(clk), .rst_n(rst_n), .exercise_en(en), .func_in(fin),
    .ex_out(xo), .vec_idx(vi), .pass_done(pd)
  );

  function automatic logic [9:0] exp_out(logic [9:0] f, bit e, int row);
    logic [9:0] r;
    for (int b = 0; b < 10; b++) begin
      if (!e || kind[b] == 0) r[b] = f[b];
      else if (kind[b] == 1)  r[b] = 1'b0;
      else if (kind[b] == 2)  r[b] = 1'b1;
      else                    r[b] = rows[row][cidx[b]];
    end
    return r;
  endfunction

  function automatic logic [9:0] mask_of(int k0, int k1);
    logic [9:0] m;
    for (int b = 0; b < 10; b++) m[b] = (kind[b] == k0 || kind[b] == k1);
    return m;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(bit e, logic [9:0] f);
    logic [9:0] ex;
    @(negedge clk);
    en  = e;
    fin = f;
    #1;
    ex = exp_out(f, e, midx);
    if (!e) chk("R1 transparent", 32'(xo), 32'(ex));
    else begin
      chk("R2 untouched", 32'(xo & mask_of(0, 0)), 32'(ex & mask_of(0, 0)));
      chk("R3 constants", 32'(xo & mask_of(1, 2)), 32'(ex & mask_of(1, 2)));
      chk("R4 table",     32'(xo & mask_of(3, 3)), 32'(ex & mask_of(3, 3)));
    end
    if (e && !prev_en)  chk("R8 entry row", 32'(vi), 32'(midx));
    else if (!prev_en)  chk("R5 cleared",   32'(vi), 32'(midx));
    else                chk("R6 index",     32'(vi), 32'(midx));
    chk("R7 pass flag", 32'(pd), 32'(e && midx == 2));
    midx    = e ? ((midx == 2) ? 0 : midx + 1) : 0;
    prev_en = e;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    fin = 10'h3FF;
    #1;
    chk("R5 reset index", 32'(vi), 32'd0);
    chk("R1 reset transparent", 32'(xo), 32'h3FF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // directed: transparent with patterns
    step(1'b0, 10'h000);
    step(1'b0, 10'h3FF);
    step(1'b0, 10'h155);
    // two full passes with complementary functional values
    for (int k = 0; k < 6; k++) step(1'b1, (k % 2) ? 10'h3FF : 10'h000);
    // cut off mid-pass, then re-enter
    step(1'b1, 10'h2AA);
    step(1'b0, 10'h2AA);
    step(1'b1, 10'h155);
    step(1'b1, 10'h0F0);
    step(1'b0, 10'h30F);
    // random mix, mostly exercise mode
    for (int k = 0; k < 300; k++) step(($urandom % 5) != 0, 10'($urandom));

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule